// File: doc/BRIEF.md
# Slot Reset Output Controller

This block drives the active-low reset line and the power-enable line of one downstream slot. A one-bit power-controller control input turns slot power on (0) or off (1). A sequencer then orders the two outputs. On power-up the power-enable output rises first, and the reset is released a programmable number of microseconds later. On power-down the reset is asserted first, and power is removed a second programmable number of microseconds later. A prescaler derives microsecond ticks from the system clock.

While the slot is powered and the power-up delay has run out, a two-bit mode input chooses what holds the reset. In power-enable mode nothing holds it. In power-good mode it is held while a synchronised power-good input is low. In hot-reset mode it is held while a hot-reset request is high. Every reset assertion is stretched in hardware to a minimum width, the one after a fundamental reset included. After a fundamental reset the pin output-enable is low, so the reset pin floats until the pin-enable input is set.

The sequencer has four states. `S_OFF` has power off and reset asserted. `S_PWR_UP` has power on, reset asserted, and the power-to-reset delay running. `S_RUN` has power on and the reset under mode control. `S_PWR_DN` has reset asserted, power still on, and the reset-to-power delay running. It has these transitions:
- `S_OFF` to `S_PWR_UP`, when the control bit is 0.
- `S_PWR_UP` to `S_RUN`, when the delay expires.
- `S_PWR_UP` or `S_RUN` to `S_PWR_DN`, when the control bit is 1.
- `S_PWR_DN` to `S_OFF`, when the delay expires.

Top module: `slot_rst_ctrl`

## Requirements
- R1: The mode code on `mode` has these meanings: 2'b00 selects power-enable mode, 2'b01 selects power-good mode, 2'b10 selects hot-reset mode, and 2'b11 behaves as power-enable mode.
- R2: Whenever `pwr_en` is low, `slot_rst_n` is low, in every mode.
- R3: With power off, driving `pwr_ctl` to 0 raises `pwr_en` within 2 clocks while `slot_rst_n` is still low.
- R4: In power-enable mode, the number of clocks from the first cycle with `pwr_en` high to the first cycle with `slot_rst_n` high is between N*CLK_PER_US and N*CLK_PER_US+2, where N is `pwr2rst_us` (in the absence of a longer minimum-width hold).
- R5: Driving `pwr_ctl` to 1 while powered pulls `slot_rst_n` low within 2 clocks while `pwr_en` is still high. `pwr_en` then falls between M*CLK_PER_US and M*CLK_PER_US+2 clocks after the reset fell, where M is `rst2pwr_us`.
- R6: Every low pulse of `slot_rst_n` lasts at least MIN_RST_US*CLK_PER_US clocks. A pulse caused by a short request lasts at most 2 clocks more than that.
- R7: After a fundamental reset, `slot_rst_n`, `pwr_en` and `slot_rst_oe` are all low. `slot_rst_oe` follows `rst_pin_en` one clock later.
- R8: In power-good mode, while powered, `slot_rst_n` stays low while `pwr_good` is low. It goes high within 4 clocks of `pwr_good` going high, and goes low within 4 clocks of `pwr_good` going low.
- R9: In hot-reset mode, `slot_rst_n` goes low one clock after `hot_rst_req` is sampled high, stays low while the request stays high, and goes high within 2 clocks of the request clearing once the minimum width is met.
- R10: In power-enable mode, while running, `pwr_good` and `hot_rst_req` have no effect on `slot_rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Fundamental reset, active low |
| rst_pin_en | input | 1 | Selects the reset function for the pin (drives the output-enable) |
| mode | input | 2 | Reset control mode code (see R1) |
| pwr_ctl | input | 1 | Power-controller control bit: 0 = power on, 1 = power off |
| pwr_good | input | 1 | Slot power-good indication, asynchronous |
| hot_rst_req | input | 1 | Hot-reset request, synchronous |
| pwr2rst_us | input | DLY_W | Power-enable to reset-release delay in microseconds |
| rst2pwr_us | input | DLY_W | Reset-assert to power-off delay in microseconds |
| pwr_en | output | 1 | Slot power-enable output |
| slot_rst_n | output | 1 | Slot reset, active low |
| slot_rst_oe | output | 1 | Output-enable for the slot reset pin |

## Verification
The bench measures the gaps between the edges of `pwr_en` and `slot_rst_n` in clocks. A sequencer that ordered the edges the wrong way, or a prescaler that counted one microsecond too many or too few, moves an edge out of its window. It runs a power-down followed at once by a zero-delay power-up, and sends one-clock hot-reset and power-good glitches. A stretcher that failed to load would then release the reset tens of clocks early. It changes the mode code while the unused inputs are active, which exposes a decoder that mishandles the spare code or lets power-enable mode react to `pwr_good` or `hot_rst_req`.

// File: rtl/slot_rst_pkg.sv
package slot_rst_pkg;

    typedef enum logic [1:0] {
        MODE_PWR_EN   = 2'b00,
        MODE_PWR_GOOD = 2'b01,
        MODE_HOT_RST  = 2'b10,
        MODE_SPARE    = 2'b11
    } rst_mode_e;

    typedef enum logic [1:0] {
        S_OFF    = 2'b00,
        S_PWR_UP = 2'b01,
        S_RUN    = 2'b10,
        S_PWR_DN = 2'b11
    } seq_state_e;

endpackage

// File: rtl/slot_rst_us_timer.sv
// Microsecond down-counter with its own prescaler; the prescaler restarts
// on every load so a load of N yields exactly N*CLK_PER_US busy clocks.
module slot_rst_us_timer #(
    parameter int CLK_PER_US = 200,
    parameter int CNT_W      = 8,
    parameter int RST_VAL    = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);
    localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);

    logic [PRE_W-1:0] pre_cnt;
    logic [CNT_W-1:0] us_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            us_cnt  <= CNT_W'(RST_VAL);
        end else if (load) begin
            pre_cnt <= '0;
            us_cnt  <= load_val;
        end else if (us_cnt != '0) begin
            if (pre_cnt == PRE_LAST) begin
                pre_cnt <= '0;
                us_cnt  <= us_cnt - 1'b1;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end

    assign busy = (us_cnt != '0);

endmodule

// File: rtl/slot_rst_sync.sv
// Multi-stage synchroniser for an asynchronous level, reset to zero.
module slot_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/slot_rst_seq.sv
// Power / reset sequencer state machine.
module slot_rst_seq
    import slot_rst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_ctl,
    input  logic [1:0] mode,
    input  logic       pg_sync,
    input  logic       hot_rst_req,
    input  logic       dly_busy,
    output logic       dly_load,
    output logic       dly_sel_dn,
    output logic       pwr_en_d,
    output logic       rst_req
);
    seq_state_e state, state_nx;
    rst_mode_e  mode_e;

    assign mode_e = rst_mode_e'(mode);

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_OFF:    if (!pwr_ctl)      state_nx = S_PWR_UP;
            S_PWR_UP: if (pwr_ctl)       state_nx = S_PWR_DN;
                      else if (!dly_busy) state_nx = S_RUN;
            S_RUN:    if (pwr_ctl)       state_nx = S_PWR_DN;
            S_PWR_DN: if (!dly_busy)     state_nx = S_OFF;
            default:                     state_nx = S_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OFF;
        else        state <= state_nx;
    end

    // Outputs
    always_comb begin
        dly_load   = 1'b0;
        dly_sel_dn = 1'b0;
        pwr_en_d   = 1'b1;
        rst_req    = 1'b1;
        unique case (state)
            S_OFF: begin
                pwr_en_d = 1'b0;
                dly_load = !pwr_ctl;
            end
            S_PWR_UP: begin
                dly_load   = pwr_ctl;
                dly_sel_dn = 1'b1;
            end
            S_RUN: begin
                dly_load   = pwr_ctl;
                dly_sel_dn = 1'b1;
                unique case (mode_e)
                    MODE_PWR_GOOD: rst_req = !pg_sync;
                    MODE_HOT_RST:  rst_req = hot_rst_req;
                    MODE_PWR_EN,
                    MODE_SPARE:    rst_req = 1'b0;
                    default:       rst_req = 1'b0;
                endcase
                if (pwr_ctl) rst_req = 1'b1;
            end
            S_PWR_DN: begin
                rst_req = 1'b1;
            end
            default: begin
                pwr_en_d = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/slot_rst_ctrl.sv
// Top: sequencer, delay timer, minimum-width stretcher, registered pins.
module slot_rst_ctrl
    import slot_rst_pkg::*;
#(
    parameter int CLK_PER_US = 200,
    parameter int MIN_RST_US = 200,
    parameter int DLY_W      = 8,
    parameter int PG_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_pin_en,
    input  logic [1:0]       mode,
    input  logic             pwr_ctl,
    input  logic             pwr_good,
    input  logic             hot_rst_req,
    input  logic [DLY_W-1:0] pwr2rst_us,
    input  logic [DLY_W-1:0] rst2pwr_us,
    output logic             pwr_en,
    output logic             slot_rst_n,
    output logic             slot_rst_oe
);
    localparam int MIN_W = $clog2(MIN_RST_US + 1);
    localparam int CNT_W = (MIN_W > DLY_W) ? MIN_W : DLY_W;

    logic             pg_sync;
    logic             dly_load, dly_sel_dn, dly_busy;
    logic             pwr_en_d, rst_req;
    logic [CNT_W-1:0] dly_val;
    logic             min_load, min_busy, rst_hold;

    slot_rst_sync #(.STAGES(PG_STAGES)) u_pg_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pwr_good),
        .q     (pg_sync)
    );

    slot_rst_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_ctl     (pwr_ctl),
        .mode        (mode),
        .pg_sync     (pg_sync),
        .hot_rst_req (hot_rst_req),
        .dly_busy    (dly_busy),
        .dly_load    (dly_load),
        .dly_sel_dn  (dly_sel_dn),
        .pwr_en_d    (pwr_en_d),
        .rst_req     (rst_req)
    );

    assign dly_val = dly_sel_dn ? CNT_W'(rst2pwr_us) : CNT_W'(pwr2rst_us);

    slot_rst_us_timer #(
        .CLK_PER_US (CLK_PER_US),
        .CNT_W      (CNT_W),
        .RST_VAL    (0)
    ) u_dly_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_load),
        .load_val (dly_val),
        .busy     (dly_busy)
    );

    // Minimum-width stretcher: loads when a request meets a released pin.
    // Starts full after fundamental reset so the first pulse is covered.
    assign min_load = rst_req && slot_rst_n;

    slot_rst_us_timer #(
        .CLK_PER_US (CLK_PER_US),
        .CNT_W      (CNT_W),
        .RST_VAL    (MIN_RST_US)
    ) u_min_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (min_load),
        .load_val (CNT_W'(MIN_RST_US)),
        .busy     (min_busy)
    );

    assign rst_hold = rst_req || min_busy;

    // Registered pin outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_en      <= 1'b0;
            slot_rst_n  <= 1'b0;
            slot_rst_oe <= 1'b0;
        end else begin
            pwr_en      <= pwr_en_d;
            slot_rst_n  <= !rst_hold;
            slot_rst_oe <= rst_pin_en;
        end
    end

endmodule

// File: rtl/slot_rst_ctrl_chk.sv
module slot_rst_ctrl_chk
    import slot_rst_pkg::*;
#(
    parameter int CLK_PER_US = 200,
    parameter int MIN_RST_US = 200
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rst_pin_en,
    input logic [1:0] mode,
    input logic       pwr_good,
    input logic       hot_rst_req,
    input logic       pwr_en,
    input logic       slot_rst_n,
    input logic       slot_rst_oe
);
    localparam int MIN_CYC = CLK_PER_US * MIN_RST_US;

    logic [31:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               low_cnt <= '0;
        else if (slot_rst_n)      low_cnt <= '0;
        else if (low_cnt < MIN_CYC) low_cnt <= low_cnt + 1'b1;
    end

    // R2: power off implies reset asserted
    p_rst_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> !slot_rst_n);

    // R3: reset only released while power is already on
    p_pwr_before_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_rst_n) |-> (pwr_en && $past(pwr_en)));

    // R5: reset asserted before power is removed
    p_rst_before_pwr_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |-> (!slot_rst_n && $past(!slot_rst_n)));

    // R6: minimum low width, checked with a counter
    p_min_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_rst_n) |-> (low_cnt >= MIN_CYC));

    // R7: output-enable follows the pin enable
    p_oe_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pin_en |=> slot_rst_oe);

    // R8: power-good low for three clocks in power-good mode holds reset
    p_pg_low_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PWR_GOOD && $past(mode == MODE_PWR_GOOD) &&
         $past(mode == MODE_PWR_GOOD, 2) && !pwr_good && $past(!pwr_good) &&
         $past(!pwr_good, 2)) |=> !slot_rst_n);

    // R9: hot-reset request asserts reset on the next clock
    p_hot_req_asserts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOT_RST && hot_rst_req) |=> !slot_rst_n);

endmodule

bind slot_rst_ctrl slot_rst_ctrl_chk #(
    .CLK_PER_US (CLK_PER_US),
    .MIN_RST_US (MIN_RST_US)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_pin_en  (rst_pin_en),
    .mode        (mode),
    .pwr_good    (pwr_good),
    .hot_rst_req (hot_rst_req),
    .pwr_en      (pwr_en),
    .slot_rst_n  (slot_rst_n),
    .slot_rst_oe (slot_rst_oe)
);

// File: tb/slot_rst_ctrl_bench.sv
`timescale 1ns/1ps
module slot_rst_ctrl_bench;

    localparam int P     = 4;
    localparam int MINUS = 10;
    localparam int MINC  = P * MINUS;
    localparam int DW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rst_pin_en = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic          pwr_ctl = 1'b1;
    logic          pwr_good = 1'b0;
    logic          hot_rst_req = 1'b0;
    logic [DW-1:0] pwr2rst_us = 8'd5;
    logic [DW-1:0] rst2pwr_us = 8'd3;
    logic          pwr_en, slot_rst_n, slot_rst_oe;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    slot_rst_ctrl #(
        .CLK_PER_US (P),
        .MIN_RST_US (MINUS),
        .DLY_W      (DW)
    ) u_slot_rst_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rst_pin_en  (rst_pin_en),
        .mode        (mode),
        .pwr_ctl     (pwr_ctl),
        .pwr_good    (pwr_good),
        .hot_rst_req (hot_rst_req),
        .pwr2rst_us  (pwr2rst_us),
        .rst2pwr_us  (rst2pwr_us),
        .pwr_en      (pwr_en),
        .slot_rst_n  (slot_rst_n),
        .slot_rst_oe (slot_rst_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_rst(input logic val, input int max, output int n);
        n = 0;
        while (slot_rst_n !== val && n < max) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_pwr(input logic val, input int max, output int n);
        n = 0;
        while (pwr_en !== val && n < max) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset_state();
        check(slot_rst_n === 1'b0, "R7 rst_n after reset", int'(slot_rst_n), 0);
        check(pwr_en === 1'b0, "R7 pwr_en after reset", int'(pwr_en), 0);
        check(slot_rst_oe === 1'b0, "R7 oe after reset", int'(slot_rst_oe), 0);
        rst_pin_en = 1'b1;
        @(negedge clk);
        check(slot_rst_oe === 1'b1, "R7 oe follows pin enable", int'(slot_rst_oe), 1);
        repeat (60) @(negedge clk);
        check(slot_rst_n === 1'b0 && pwr_en === 1'b0, "R2 reset held while power off",
              int'(slot_rst_n), 0);
    endtask

    task automatic t_power_on_pe();
        int n;
        mode = 2'b00;
        pwr2rst_us = 8'd5;
        pwr_ctl = 1'b0;
        wait_pwr(1'b1, 5, n);
        check(n <= 2 && pwr_en === 1'b1, "R3 pwr_en rise latency", n, 2);
        check(slot_rst_n === 1'b0, "R3 reset still low at power-on", int'(slot_rst_n), 0);
        wait_rst(1'b1, 100, n);
        check(n >= 5 * P && n <= 5 * P + 2, "R4 power-to-reset gap", n, 5 * P + 1);
    endtask

    task automatic t_pe_ignores();
        bit ok = 1'b1;
        pwr_good = 1'b0;
        hot_rst_req = 1'b1;
        repeat (10) begin
            @(negedge clk);
            if (slot_rst_n !== 1'b1) ok = 1'b0;
        end
        check(ok, "R10 power-enable mode ignores pg and hot req", int'(slot_rst_n), 1);
        hot_rst_req = 1'b0;
        pwr_good = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_power_off();
        int n;
        rst2pwr_us = 8'd3;
        pwr_ctl = 1'b1;
        wait_rst(1'b0, 5, n);
        check(n <= 2 && pwr_en === 1'b1, "R5 reset first on power-off", n, 1);
        wait_pwr(1'b0, 50, n);
        check(n >= 3 * P && n <= 3 * P + 2, "R5 reset-to-power gap", n, 3 * P + 1);
        repeat (3) @(negedge clk);
        check(slot_rst_n === 1'b0, "R2 reset low after power-off", int'(slot_rst_n), 0);
    endtask

    task automatic t_min_width();
        int n;
        pwr2rst_us = 8'd0;
        pwr_ctl = 1'b0;
        wait_rst(1'b1, 200, n);
        repeat (2) @(negedge clk);
        rst2pwr_us = 8'd1;
        pwr_ctl = 1'b1;
        wait_rst(1'b0, 5, n);
        pwr_ctl = 1'b0;
        wait_rst(1'b1, 200, n);
        check(n >= MINC && n <= MINC + 2, "R6 min width on fast power cycle", n, MINC + 1);
        check(pwr_en === 1'b1, "R3 power back on", int'(pwr_en), 1);
    endtask

    task automatic t_hot_reset();
        int n;
        bit ok = 1'b1;
        mode = 2'b10;
        pwr_good = 1'b0;
        @(negedge clk);
        check(slot_rst_n === 1'b1, "R1 hot mode ignores pg", int'(slot_rst_n), 1);
        hot_rst_req = 1'b1;
        @(negedge clk);
        hot_rst_req = 1'b0;
        check(slot_rst_n === 1'b0, "R9 hot req asserts next clock", int'(slot_rst_n), 0);
        wait_rst(1'b1, 200, n);
        check(n >= MINC && n <= MINC + 2, "R6 min width on one-clock hot req", n, MINC + 1);
        repeat (3) @(negedge clk);
        hot_rst_req = 1'b1;
        @(negedge clk);
        repeat (80) begin
            @(negedge clk);
            if (slot_rst_n !== 1'b0) ok = 1'b0;
        end
        check(ok, "R9 reset held while request high", int'(slot_rst_n), 0);
        hot_rst_req = 1'b0;
        wait_rst(1'b1, 5, n);
        check(n <= 2 && slot_rst_n === 1'b1, "R9 release after request clears", n, 1);
    endtask

    task automatic t_power_good();
        int n;
        int k;
        mode = 2'b01;
        pwr_good = 1'b0;
        wait_rst(1'b0, 6, n);
        check(n <= 4 && slot_rst_n === 1'b0, "R8 reset on pg low", n, 3);
        repeat (60) @(negedge clk);
        check(slot_rst_n === 1'b0, "R8 held while pg low", int'(slot_rst_n), 0);
        pwr_good = 1'b1;
        wait_rst(1'b1, 6, n);
        check(n <= 4 && slot_rst_n === 1'b1, "R8 release on pg high", n, 3);
        repeat (3) @(negedge clk);
        pwr_good = 1'b0;
        wait_rst(1'b0, 6, n);
        check(n <= 4 && slot_rst_n === 1'b0, "R8 reassert on pg drop", n, 3);
        k = 0;
        repeat (5) begin
            @(negedge clk);
            k++;
        end
        pwr_good = 1'b1;
        wait_rst(1'b1, 200, n);
        check(k + n >= MINC && k + n <= MINC + 4, "R6 min width on pg glitch", k + n, MINC + 1);
    endtask

    task automatic t_spare_mode();
        bit ok = 1'b1;
        repeat (2) @(negedge clk);
        mode = 2'b11;
        pwr_good = 1'b0;
        hot_rst_req = 1'b1;
        repeat (12) begin
            @(negedge clk);
            if (slot_rst_n !== 1'b1) ok = 1'b0;
        end
        check(ok, "R1 spare code acts as power-enable mode", int'(slot_rst_n), 1);
        hot_rst_req = 1'b0;
        mode = 2'b01;
        repeat (6) @(negedge clk);
        check(slot_rst_n === 1'b0, "R1 code 01 selects power-good mode", int'(slot_rst_n), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_power_on_pe();
        t_pe_ignores();
        t_power_off();
        t_min_width();
        t_hot_reset();
        t_power_good();
        t_spare_mode();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule